// File: doc/BRIEF.md
# Flash Transfer Chunking Sequencer

This block sits between a command source and a serial shift engine that talks to a serial NOR flash device. It takes one flash command at a time: an opcode, a 24-bit address, a byte length and two direction flags. It turns that command into a series of engine transactions. Each transaction moves at most one 32-bit word of data. The sequencer decodes the opcode, which sets how many address bytes go out and how many fixed data or response bytes the transaction carries. It rewrites a fast read as a plain read and drops the dummy byte. It rejects opcodes it does not know.

A read is split into word-sized transactions. The flash address advances by the number of bytes each one moved. A program is split the same way, but the flash device needs more work around each chunk. Every chunk is followed by status-register polling until the write-in-progress bit clears. Every chunk after the first is preceded by a write-enable transaction. Received words come out on a strobe together with their byte count. Program data is pulled one word per chunk through a take strobe. When the command ends, the block raises a one-cycle done pulse, or a one-cycle error pulse if the command was rejected.

The control is a single state machine with these states:
- `S_IDLE` accepts a command.
- `S_ISSUE` launches a transaction once the engine is idle.
- `S_ARM` gives the engine one cycle to raise busy.
- `S_WAIT` waits for busy to fall and then decides what comes next.
- `S_FINISH` pulses done.
- `S_FAIL` pulses the error.

The transitions are:
- IDLE→FAIL on a rejected command, and IDLE→ISSUE on an accepted one.
- ISSUE→ARM when the engine is idle.
- ARM→WAIT unconditionally.
- WAIT→ISSUE when another transaction follows (next read chunk, poll, repeated poll, write-enable, or the program chunk after a write-enable).
- WAIT→FINISH after the last transaction.
- FINISH→IDLE and FAIL→IDLE.

Top module: `flash_chunk_seq`

## Requirements
- R1: The opcode decides the engine transaction. Each case below gives the opcode, then the engine tx count (opcode + address + data bytes), then the rx count:
  - 0x06, 0x04 and 0xC7: tx 1, rx 0.
  - 0x9F: tx 1, rx 3.
  - 0x05: tx 1, rx 1.
  - 0x01: tx 2, rx 0. Its data byte is bits 7:0 of `wr_word`.
  - 0xAB: tx 4, rx 1.
  - 0xD8: tx 4, rx 0.
  - Opcodes with 3 address bytes send `cmd_addr`. All others present address 0.
  - `cmd_len` is ignored for all of these single-transaction commands.
- R2: The fast-read opcode 0x0B behaves exactly like read 0x03. The engine only ever sees opcode 0x03, with tx 4, and no dummy byte is sent.
- R3: An opcode not listed in R1, R2 or R7, or a command with both `cmd_rd` and `cmd_wr` set, produces a one-cycle `err` pulse in the cycle after acceptance and launches no engine transaction.
- R4: A read of L bytes is issued as transactions of min(remaining, 4) bytes. Each has opcode 0x03, tx 4 and rx equal to the chunk size. The address of each chunk is the previous address plus the previous chunk size.
- R5: Every transaction issued for the command itself with a nonzero rx count produces one `rd_valid` pulse. `rd_word` then holds the engine's received word, with the first byte in bits 7:0, and `rd_bytes` holds the byte count.
- R6: A program chunk is followed by status polls: opcode 0x05, tx 1, rx 1, address 0. Polling repeats while bit 0 of the received status is 1 and stops at the first poll that reads 0.
- R7: A program (0x02) of L bytes is issued as chunks of min(remaining, 4) bytes, each with tx 4 + chunk and rx 0. Every chunk after the first is preceded by a write-enable (0x06, tx 1, rx 0, address 0). Each chunk with data pulses `wr_take` once and sends `wr_word` masked to the chunk's bytes.
- R8: `done` pulses for one cycle after the last transaction completes. For a program, the last transaction is the final status poll; for a read, it is the chunk that leaves no bytes. `cmd_ready` is high only when the block is idle.
- R9: `eng_start` is raised only while `eng_busy` is low. At most one transaction is in flight, and completion is taken from `eng_busy` falling.
- R10: A read or program with length 0 issues a single opcode-plus-address transaction with no data bytes and no `rd_valid`. A program of length 0 still polls status.
- R11: After reset, `cmd_ready` is 1 and `done`, `err`, `eng_start`, `wr_take` and `rd_valid` are 0.
- R12: The chunk address advances modulo 2^24. A read that starts at 0xFFFFFE continues at 0x000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_opcode | input | 8 | Flash opcode |
| cmd_addr | input | 24 | Flash start address |
| cmd_len | input | 16 | Data length in bytes for read and program |
| cmd_rd | input | 1 | Command expects read data |
| cmd_wr | input | 1 | Command supplies write data |
| wr_word | input | 32 | Next program or status-write data word, first byte in bits 7:0 |
| wr_take | output | 1 | Pulse: `wr_word` consumed this cycle |
| rd_word | output | 32 | Received data word |
| rd_bytes | output | 3 | Valid byte count of `rd_word` |
| rd_valid | output | 1 | Pulse: `rd_word` and `rd_bytes` valid |
| done | output | 1 | Pulse: command completed |
| err | output | 1 | Pulse: command rejected |
| eng_start | output | 1 | Launch a transaction on the shift engine |
| eng_opcode | output | 8 | Transaction opcode |
| eng_addr | output | 24 | Transaction address |
| eng_tx_cnt | output | 4 | Bytes sent: opcode, address and data |
| eng_rx_cnt | output | 3 | Bytes received |
| eng_tx_data | output | 32 | Data bytes sent after the address |
| eng_busy | input | 1 | Engine busy; rises within one cycle of start |
| eng_rx_data | input | 32 | Received bytes, valid when busy falls |

## Verification
All 256 opcode values are swept with a five-byte length. This separates the legal single-transaction opcodes from the chunked ones and from the rejected ones, and it exposes any wrong tx or rx count for an opcode. Reads of lengths 0 to 9 are run at a plain address, at an address whose low byte crosses a boundary, and at the top of the address space. Together these cover partial final chunks, the empty transfer and address wrap. Programs of lengths 0 to 9 are run against an engine model that reports the status busy bit for 0, 1 or 2 polls. This tells apart missing or extra write-enables, polls that stop early or late, and data words taken out of order. Both-direction commands are rejected for a chunked opcode and for a fixed opcode.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_RDID   = 8'hAB;

    localparam int ADDR_BYTES = 3;

    typedef enum logic [1:0] {
        CK_FIXED = 2'd0,
        CK_READ  = 2'd1,
        CK_PROG  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        TX_MAIN = 2'd0,
        TX_WREN = 2'd1,
        TX_POLL = 2'd2
    } txn_kind_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_ARM    = 3'd2,
        S_WAIT   = 3'd3,
        S_FINISH = 3'd4,
        S_FAIL   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic       legal;
        cmd_kind_e  kind;
        logic [7:0] wire_op;
        logic [2:0] addr_bytes;
        logic [2:0] fix_tx;
        logic [2:0] fix_rx;
    } op_info_t;

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
    import flash_seq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);

    always_comb begin
        info.legal      = 1'b1;
        info.kind       = CK_FIXED;
        info.wire_op    = opcode;
        info.addr_bytes = 3'd0;
        info.fix_tx     = 3'd0;
        info.fix_rx     = 3'd0;
        case (opcode)
            OP_WREN, OP_WRDI, OP_CERASE: ;
            OP_JEDEC:  info.fix_rx = 3'd3;
            OP_RDSR:   info.fix_rx = 3'd1;
            OP_WRSR:   info.fix_tx = 3'd1;
            OP_RDID: begin
                info.addr_bytes = 3'(ADDR_BYTES);
                info.fix_rx     = 3'd1;
            end
            OP_SERASE: info.addr_bytes = 3'(ADDR_BYTES);
            OP_READ, OP_FREAD: begin
                info.kind       = CK_READ;
                info.wire_op    = OP_READ;
                info.addr_bytes = 3'(ADDR_BYTES);
            end
            OP_PROG: begin
                info.kind       = CK_PROG;
                info.addr_bytes = 3'(ADDR_BYTES);
            end
            default:   info.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_chunk_calc.sv
module flash_chunk_calc #(
    parameter  int LEN_W      = 16,
    parameter  int ADDR_W     = 24,
    parameter  int WORD_BYTES = 4,
    localparam int CNT_W      = $clog2(WORD_BYTES + 1)
) (
    input  logic [LEN_W-1:0]  rem,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  chunk,
    output logic [LEN_W-1:0]  rem_next,
    output logic [ADDR_W-1:0] addr_next,
    output logic              last
);

    always_comb begin
        if (rem >= LEN_W'(WORD_BYTES)) begin
            chunk = CNT_W'(WORD_BYTES);
        end else begin
            chunk = rem[CNT_W-1:0];
        end
        rem_next  = rem - LEN_W'(chunk);
        addr_next = addr + ADDR_W'(chunk);
        last      = (rem_next == '0);
    end

endmodule

// File: rtl/flash_byte_mask.sv
module flash_byte_mask #(
    parameter  int WORD_BYTES = 4,
    localparam int CNT_W      = $clog2(WORD_BYTES + 1),
    localparam int DW         = 8 * WORD_BYTES
) (
    input  logic [CNT_W-1:0] count,
    output logic [DW-1:0]    mask
);

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign mask[8*b +: 8] = {8{count > CNT_W'(b)}};
    end

endmodule

// File: rtl/flash_chunk_seq.sv
module flash_chunk_seq
    import flash_seq_pkg::*;
#(
    parameter  int ADDR_W          = 24,
    parameter  int LEN_W           = 16,
    parameter  int WORD_BYTES      = 4,
    parameter  int STATUS_BUSY_BIT = 0,
    localparam int DW              = 8 * WORD_BYTES,
    localparam int CNT_W           = $clog2(WORD_BYTES + 1),
    localparam int TXC_W           = $clog2(1 + ADDR_BYTES + WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [DW-1:0]     wr_word,
    output logic              wr_take,
    output logic [DW-1:0]     rd_word,
    output logic [CNT_W-1:0]  rd_bytes,
    output logic              rd_valid,
    output logic              done,
    output logic              err,
    output logic              eng_start,
    output logic [7:0]        eng_opcode,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [TXC_W-1:0]  eng_tx_cnt,
    output logic [CNT_W-1:0]  eng_rx_cnt,
    output logic [DW-1:0]     eng_tx_data,
    input  logic              eng_busy,
    input  logic [DW-1:0]     eng_rx_data
);

    seq_state_e  state_q, state_d;
    txn_kind_e   txn_q;
    cmd_kind_e   kind_q;
    logic [7:0]  wire_op_q;
    logic [2:0]  ab_q, fix_tx_q, fix_rx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cur_rx_q;

    op_info_t          info;
    logic [CNT_W-1:0]  chunk;
    logic [LEN_W-1:0]  rem_next;
    logic [ADDR_W-1:0] addr_next;
    logic              last_chunk;
    logic [CNT_W-1:0]  data_cnt;
    logic [DW-1:0]     data_mask;
    logic              reject;
    logic              eng_idle_done;
    logic              status_busy;

    flash_op_decode u_decode (
        .opcode (cmd_opcode),
        .info   (info)
    );

    flash_chunk_calc #(
        .LEN_W      (LEN_W),
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_chunk (
        .rem       (rem_q),
        .addr      (addr_q),
        .chunk     (chunk),
        .rem_next  (rem_next),
        .addr_next (addr_next),
        .last      (last_chunk)
    );

    flash_byte_mask #(
        .WORD_BYTES (WORD_BYTES)
    ) u_mask (
        .count (data_cnt),
        .mask  (data_mask)
    );

    assign reject        = !info.legal || (cmd_rd && cmd_wr);
    assign eng_idle_done = !eng_busy;
    assign status_busy   = eng_rx_data[STATUS_BUSY_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    state_d = reject ? S_FAIL : S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (!eng_busy) state_d = S_ARM;
            end
            S_ARM: state_d = S_WAIT;
            S_WAIT: begin
                if (eng_idle_done) begin
                    unique case (txn_q)
                        TX_MAIN: begin
                            if (kind_q == CK_FIXED) begin
                                state_d = S_FINISH;
                            end else if (kind_q == CK_READ && last_chunk) begin
                                state_d = S_FINISH;
                            end else begin
                                state_d = S_ISSUE;
                            end
                        end
                        TX_WREN: state_d = S_ISSUE;
                        TX_POLL: begin
                            if (status_busy)        state_d = S_ISSUE;
                            else if (rem_q == '0)   state_d = S_FINISH;
                            else                    state_d = S_ISSUE;
                        end
                        default: state_d = S_IDLE;
                    endcase
                end
            end
            S_FINISH: state_d = S_IDLE;
            S_FAIL:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        cmd_ready   = (state_q == S_IDLE);
        done        = (state_q == S_FINISH);
        err         = (state_q == S_FAIL);
        eng_start   = (state_q == S_ISSUE) && !eng_busy;
        eng_opcode  = 8'h00;
        eng_addr    = '0;
        eng_tx_cnt  = '0;
        eng_rx_cnt  = '0;
        data_cnt    = '0;
        if (state_q == S_ISSUE) begin
            unique case (txn_q)
                TX_WREN: begin
                    eng_opcode = OP_WREN;
                    eng_tx_cnt = TXC_W'(1);
                end
                TX_POLL: begin
                    eng_opcode = OP_RDSR;
                    eng_tx_cnt = TXC_W'(1);
                    eng_rx_cnt = CNT_W'(1);
                end
                TX_MAIN: begin
                    eng_opcode = wire_op_q;
                    eng_addr   = (ab_q != 3'd0) ? addr_q : '0;
                    unique case (kind_q)
                        CK_READ: begin
                            eng_rx_cnt = chunk;
                        end
                        CK_PROG: begin
                            data_cnt = chunk;
                        end
                        default: begin
                            data_cnt   = CNT_W'(fix_tx_q);
                            eng_rx_cnt = CNT_W'(fix_rx_q);
                        end
                    endcase
                    eng_tx_cnt = TXC_W'(1) + TXC_W'(ab_q) + TXC_W'(data_cnt);
                end
                default: ;
            endcase
        end
        eng_tx_data = wr_word & data_mask;
        wr_take     = eng_start && (data_cnt != '0);
    end

    // Command context and chunk progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_q     <= TX_MAIN;
            kind_q    <= CK_FIXED;
            wire_op_q <= 8'h00;
            ab_q      <= 3'd0;
            fix_tx_q  <= 3'd0;
            fix_rx_q  <= 3'd0;
            addr_q    <= '0;
            rem_q     <= '0;
            cur_rx_q  <= '0;
            rd_valid  <= 1'b0;
            rd_word   <= '0;
            rd_bytes  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (state_q == S_IDLE && cmd_valid && !reject) begin
                txn_q     <= TX_MAIN;
                kind_q    <= info.kind;
                wire_op_q <= info.wire_op;
                ab_q      <= info.addr_bytes;
                fix_tx_q  <= info.fix_tx;
                fix_rx_q  <= info.fix_rx;
                addr_q    <= cmd_addr;
                rem_q     <= (info.kind == CK_FIXED) ? '0 : cmd_len;
            end
            if (eng_start) begin
                cur_rx_q <= eng_rx_cnt;
            end
            if (state_q == S_WAIT && eng_idle_done) begin
                unique case (txn_q)
                    TX_MAIN: begin
                        if (cur_rx_q != '0) begin
                            rd_valid <= 1'b1;
                            rd_word  <= eng_rx_data;
                            rd_bytes <= cur_rx_q;
                        end
                        if (kind_q != CK_FIXED) begin
                            addr_q <= addr_next;
                            rem_q  <= rem_next;
                        end
                        if (kind_q == CK_PROG) txn_q <= TX_POLL;
                    end
                    TX_WREN: txn_q <= TX_MAIN;
                    TX_POLL: begin
                        if (!status_busy) txn_q <= TX_WREN;
                    end
                    default: txn_q <= TX_MAIN;
                endcase
            end
        end
    end

    // R9
    // A launch is followed by at least one cycle without a launch
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2
    fast_read_rewritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> eng_opcode != OP_FREAD);

    // R4
    read_chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_opcode == OP_READ) |->
            (eng_rx_cnt <= CNT_W'(WORD_BYTES) && eng_tx_cnt == TXC_W'(1 + ADDR_BYTES)));

    // R3
    both_dir_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_rd && cmd_wr) |=> (err && !eng_start));

    // R5
    rd_bytes_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_bytes != '0 && rd_bytes <= CNT_W'(WORD_BYTES)));

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_ready && !done));

    // R7
    take_only_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (eng_start && eng_rx_cnt == '0));

endmodule

// File: tb/flash_chunk_seq_tb.sv
module flash_chunk_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ENG_LAT    = 3;
    localparam int LOG_N      = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic [15:0] cmd_len = 16'h0;
    logic        cmd_rd = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] wr_word;
    logic        wr_take;
    logic [31:0] rd_word;
    logic [2:0]  rd_bytes;
    logic        rd_valid;
    logic        done;
    logic        err;
    logic        eng_start;
    logic [7:0]  eng_opcode;
    logic [23:0] eng_addr;
    logic [3:0]  eng_tx_cnt;
    logic [2:0]  eng_rx_cnt;
    logic [31:0] eng_tx_data;
    logic        eng_busy = 1'b0;
    logic [31:0] eng_rx_data = 32'h0;

    int checks = 0;
    int errors = 0;
    int wseq = 0;
    int poll_busy = 0;
    int polls_left = 0;
    int lat_cnt = 0;
    int cyc = 0;
    logic [31:0] pend_rx = 32'h0;

    logic [7:0]  lg_op   [LOG_N];
    logic [23:0] lg_addr [LOG_N];
    logic [3:0]  lg_tx   [LOG_N];
    logic [2:0]  lg_rx   [LOG_N];
    logic [31:0] lg_data [LOG_N];
    int          lg_n = 0;
    logic [31:0] rv_word [LOG_N];
    logic [2:0]  rv_bytes[LOG_N];
    int          rv_n = 0;

    logic [7:0]  ex_op   [64];
    logic [23:0] ex_addr [64];
    logic [3:0]  ex_tx   [64];
    logic [2:0]  ex_rx   [64];
    logic [31:0] ex_data [64];
    int          ex_n;
    logic [31:0] er_word [16];
    logic [2:0]  er_bytes[16];
    int          er_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(input int k);
        return 32'hA1B2C3D4 + 32'(k) * 32'h01010101;
    endfunction

    function automatic logic [31:0] mask_of(input int c);
        logic [31:0] m = 32'h0;
        for (int i = 0; i < 4; i++) if (i < c) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] read_pat(input logic [23:0] a, input int c);
        logic [31:0] w = 32'h0;
        for (int i = 0; i < 4; i++) begin
            logic [23:0] ai = a + 24'(i);
            if (i < c) w[8*i +: 8] = ai[7:0] ^ 8'h5A;
        end
        return w;
    endfunction

    assign wr_word = word_of(wseq);

    flash_chunk_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_opcode  (cmd_opcode),
        .cmd_addr    (cmd_addr),
        .cmd_len     (cmd_len),
        .cmd_rd      (cmd_rd),
        .cmd_wr      (cmd_wr),
        .wr_word     (wr_word),
        .wr_take     (wr_take),
        .rd_word     (rd_word),
        .rd_bytes    (rd_bytes),
        .rd_valid    (rd_valid),
        .done        (done),
        .err         (err),
        .eng_start   (eng_start),
        .eng_opcode  (eng_opcode),
        .eng_addr    (eng_addr),
        .eng_tx_cnt  (eng_tx_cnt),
        .eng_rx_cnt  (eng_rx_cnt),
        .eng_tx_data (eng_tx_data),
        .eng_busy    (eng_busy),
        .eng_rx_data (eng_rx_data)
    );

    // Shift engine and flash model: logs launches and returns responses
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_take) wseq <= wseq + 1;
        if (rd_valid && rv_n < LOG_N) begin
            rv_word[rv_n]  <= rd_word;
            rv_bytes[rv_n] <= rd_bytes;
            rv_n <= rv_n + 1;
        end
        if (eng_start) begin
            if (lg_n < LOG_N) begin
                lg_op[lg_n]   <= eng_opcode;
                lg_addr[lg_n] <= eng_addr;
                lg_tx[lg_n]   <= eng_tx_cnt;
                lg_rx[lg_n]   <= eng_rx_cnt;
                lg_data[lg_n] <= eng_tx_data;
                lg_n <= lg_n + 1;
            end
            eng_busy <= 1'b1;
            lat_cnt  <= ENG_LAT;
            case (eng_opcode)
                8'h03: pend_rx <= read_pat(eng_addr, int'(eng_rx_cnt));
                8'h05: begin
                    pend_rx <= (polls_left > 0) ? 32'h1 : 32'h0;
                    if (polls_left > 0) polls_left <= polls_left - 1;
                end
                8'h9F: pend_rx <= 32'h001820C2 & mask_of(int'(eng_rx_cnt));
                8'hAB: pend_rx <= 32'h00000014;
                8'h02: begin
                    pend_rx    <= 32'h0;
                    polls_left <= poll_busy;
                end
                default: pend_rx <= 32'h0;
            endcase
        end else if (eng_busy) begin
            if (lat_cnt <= 1) begin
                eng_busy    <= 1'b0;
                eng_rx_data <= pend_rx;
            end
            lat_cnt <= lat_cnt - 1;
        end
    end

    task automatic chk(input logic ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] op, input logic [23:0] a, input int tx, input int rx, input logic [31:0] d);
        if (ex_n < 64) begin
            ex_op[ex_n] = op; ex_addr[ex_n] = a; ex_tx[ex_n] = 4'(tx);
            ex_rx[ex_n] = 3'(rx); ex_data[ex_n] = d;
            ex_n++;
        end
    endtask

    task automatic push_rd(input logic [31:0] w, input int c);
        if (er_n < 16) begin
            er_word[er_n] = w; er_bytes[er_n] = 3'(c); er_n++;
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int len,
                           input logic rd, input logic wr, input int busyn);
        int lg0, rv0, k, rem, c, kind, ftx, frx, ab, t;
        logic [23:0] ad;
        logic legal, exp_err, got_err, got_done;
        // Expected transactions per R1, R2, R4, R6, R7, R10, R12
        ex_n = 0; er_n = 0; legal = 1'b1; kind = 0; ftx = 0; frx = 0; ab = 0;
        case (op)
            8'h06, 8'h04, 8'hC7: ;
            8'h9F: frx = 3;
            8'h05: frx = 1;
            8'h01: ftx = 1;
            8'hAB: begin ab = 3; frx = 1; end
            8'hD8: ab = 3;
            8'h03, 8'h0B: kind = 1;
            8'h02: kind = 2;
            default: legal = 1'b0;
        endcase
        exp_err = !legal || (rd && wr);
        k = wseq;
        if (!exp_err) begin
            if (kind == 0) begin
                push(op, (ab == 3) ? a : 24'h0, 1 + ab + ftx, frx,
                     (ftx > 0) ? (word_of(k) & mask_of(ftx)) : 32'h0);
                if (frx > 0) begin
                    case (op)
                        8'h9F:   push_rd(32'h001820C2, frx);
                        8'hAB:   push_rd(32'h00000014, frx);
                        default: push_rd(32'h0, frx);
                    endcase
                end
            end else if (kind == 1) begin
                rem = len; ad = a;
                do begin
                    c = (rem > 4) ? 4 : rem;
                    push(8'h03, ad, 4, c, 32'h0);
                    if (c > 0) push_rd(read_pat(ad, c), c);
                    ad = ad + 24'(c); rem = rem - c;
                end while (rem > 0);
            end else begin
                rem = len; ad = a; t = 0;
                do begin
                    c = (rem > 4) ? 4 : rem;
                    if (t > 0) push(8'h06, 24'h0, 1, 0, 32'h0);
                    push(8'h02, ad, 4 + c, 0, (c > 0) ? (word_of(k) & mask_of(c)) : 32'h0);
                    if (c > 0) k++;
                    for (int p = 0; p <= busyn; p++) push(8'h05, 24'h0, 1, 1, 32'h0);
                    ad = ad + 24'(c); rem = rem - c; t++;
                end while (rem > 0);
            end
        end

        poll_busy = busyn;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        lg0 = lg_n; rv0 = rv_n;
        cmd_opcode = op; cmd_addr = a; cmd_len = 16'(len); cmd_rd = rd; cmd_wr = wr;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_err = 1'b0; got_done = 1'b0;
        for (int w = 0; w < 4000; w++) begin
            if (done || err) begin
                got_err = err; got_done = done;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        // R3 / R8: completion kind
        chk(got_err == exp_err && got_done == !exp_err,
            $sformatf("R3 R8 op %h end kind {err,done}", op),
            {62'h0, got_err, got_done}, {62'h0, exp_err, !exp_err});
        // R1 R4 R6 R7: transaction count
        chk((lg_n - lg0) == ex_n, $sformatf("R1 R4 R6 R7 op %h len %0d txn count", op, len),
            64'(lg_n - lg0), 64'(ex_n));
        for (int i = 0; i < ex_n && (lg0 + i) < lg_n; i++) begin
            chk(lg_op[lg0+i] == ex_op[i] && lg_addr[lg0+i] == ex_addr[i] &&
                lg_tx[lg0+i] == ex_tx[i] && lg_rx[lg0+i] == ex_rx[i] &&
                lg_data[lg0+i] == ex_data[i],
                $sformatf("R1 R2 R4 R7 R12 op %h len %0d txn %0d {op,addr,tx,rx,data}", op, len, i),
                {lg_op[lg0+i], lg_addr[lg0+i], 1'b0, lg_rx[lg0+i], lg_data[lg0+i][27:0]},
                {ex_op[i], ex_addr[i], 1'b0, ex_rx[i], ex_data[i][27:0]});
        end
        // R5 / R10: received words
        chk((rv_n - rv0) == er_n, $sformatf("R5 R10 op %h len %0d rd_valid count", op, len),
            64'(rv_n - rv0), 64'(er_n));
        for (int i = 0; i < er_n && (rv0 + i) < rv_n; i++) begin
            chk(rv_word[rv0+i] == er_word[i] && rv_bytes[rv0+i] == er_bytes[i],
                $sformatf("R5 op %h word %0d {bytes,word}", op, i),
                {29'h0, rv_bytes[rv0+i], rv_word[rv0+i]}, {29'h0, er_bytes[i], er_word[i]});
        end
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(cmd_ready && !done && !err && !eng_start && !wr_take && !rd_valid,
            "R11 reset outputs {ready,done,err,start,take,rvalid}",
            {58'h0, cmd_ready, done, err, eng_start, wr_take, rd_valid}, 64'h20);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_ready && !eng_start, "R11 idle after reset release",
            {62'h0, cmd_ready, eng_start}, 64'h2);

        // R1 R2 R3: every opcode value
        for (int op = 0; op < 256; op++) begin
            run_cmd(8'(op), 24'h123456, 5, (op == 3 || op == 11), (op == 2), 1);
        end
        // R4 R10 R12: read lengths at several addresses
        for (int ai = 0; ai < 3; ai++) begin
            for (int len = 0; len < 10; len++) begin
                run_cmd(8'h03, (ai == 0) ? 24'h000000 : (ai == 1) ? 24'h000FFD : 24'hFFFFFE,
                        len, 1'b1, 1'b0, 0);
            end
        end
        // R2: fast read chunked like read
        run_cmd(8'h0B, 24'h00ABCD, 7, 1'b1, 1'b0, 0);
        // R6 R7 R10: program lengths against varied busy durations
        for (int b = 0; b < 3; b++) begin
            for (int len = 0; len < 10; len++) begin
                run_cmd(8'h02, 24'h000200 + 24'(len), len, 1'b0, 1'b1, b);
            end
        end
        // R3: both directions requested
        run_cmd(8'h03, 24'h000010, 4, 1'b1, 1'b1, 0);
        run_cmd(8'h06, 24'h000000, 0, 1'b1, 1'b1, 0);
        // R1: fixed commands ignore length
        run_cmd(8'h9F, 24'h000000, 300, 1'b1, 1'b0, 0);
        run_cmd(8'hD8, 24'h7F0000, 9, 1'b0, 1'b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule